// File: doc/BRIEF.md
# Edge-Capture Down-Counter with Optional Preset

This block is a 16-bit down-counter that decrements once for every clock-enable tick while the timer is enabled. A single external capture pin is brought into the clock domain through a flop synchronizer and then edge-detected. Software picks whether rising or falling edges count. Each detected edge copies the running count into a capture register.

When preset is enabled, the same edge also reloads the counter with all ones once the count has been captured. Each captured value then gives the interval between consecutive edges in ticks, taken as all-ones minus the captured value. The counter wraps from zero to all ones when it underflows.

Two event flags, one for capture and one for underflow, each latch until software clears them with a write-one strobe. Each flag has its own enable into a single interrupt line.

Top module: `cap_timer`

## Requirements
- R1: After reset the capture register reads 0000h, both pending flags and the interrupt line are low, and the counter holds FFFFh.
- R2: The counter drops by exactly one on every clock where both the timer enable and the tick are high. It holds its value on any other clock, unless R5 applies.
- R3: When the counter is 0000h and a tick arrives with the timer enabled, the counter becomes FFFFh and the underflow pending flag is set.
- R4: The capture pin passes through two synchronizing flops. An edge driven just before clock edge k is acted on at clock edge k+2. At that edge the capture register loads the count held before that edge, ignoring any decrement in the same cycle.
- R5: With preset enabled (preset_en_i = 1), a capture event also loads the counter with FFFFh. This takes priority over a decrement in the same cycle.
- R6: Every capture event sets the capture pending flag.
- R7: When a capture event and an underflow happen on the same clock, both pending flags are set. The counter ends at FFFFh and the captured value is 0000h.
- R8: Each pending flag is cleared by a one-clock high on its own clear strobe. If the flag's set event occurs on the same clock as its clear, the set wins.
- R9: irq_o is high exactly when (capture pending AND capture enable) OR (underflow pending AND underflow enable). It follows enable changes in the same cycle.
- R10: edge_sel_i = 0 selects rising edges and edge_sel_i = 1 selects falling edges. Edges of the other direction do not change the capture register or the capture flag. A pin level held for one clock is enough to be recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Counting clock enable |
| timer_en_i | input | 1 | Allows the counter to decrement |
| cap_pin_i | input | 1 | Asynchronous capture input |
| edge_sel_i | input | 1 | 0 = rising edges, 1 = falling edges |
| preset_en_i | input | 1 | Reload counter with FFFFh on capture |
| cap_ie_i | input | 1 | Capture interrupt enable |
| unf_ie_i | input | 1 | Underflow interrupt enable |
| cap_clr_i | input | 1 | Write-one clear of capture pending |
| unf_clr_i | input | 1 | Write-one clear of underflow pending |
| cap_val_o | output | 16 | Capture register |
| cap_pend_o | output | 1 | Capture pending flag |
| unf_pend_o | output | 1 | Underflow pending flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that every input except the capture pin is synchronous to clk_i. The capture pin may change at any time, but a level must hold for at least one clock. The assertions also assume that the clear strobes and enables are sampled at rising edges, so a single-cycle strobe means a single clear.

The stimulus drives every input on the falling clock edge, so no input moves near a sampling edge. Capture pulses always keep each level for at least one full clock, as the minimum-width rule requires. The random phase also changes pin, tick and strobes only once per cycle.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;

  localparam int unsigned SRC_CAP = 0;
  localparam int unsigned SRC_UNF = 1;
  localparam int unsigned SRC_N   = 2;
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge
  import cap_timer_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_i,
  input  edge_pol_e pol_i,
  output logic      evt_o
);
  localparam int unsigned CHAIN_W = SYNC_N + 1;

  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic               lvl_now, lvl_old;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign lvl_now = chain_q[SYNC_N-1];
  assign lvl_old = chain_q[SYNC_N];

  always_comb begin
    if (pol_i == EDGE_RISE) evt_o = lvl_now & ~lvl_old;
    else                    evt_o = ~lvl_now & lvl_old;
  end

  // R10: a detected edge is a single-cycle pulse
  assert_evt_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && $stable(pol_i)) |=> !(evt_o && $stable(pol_i)));
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             cap_evt_i,
  input  logic             preset_en_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             unf_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic             cnt_ce, do_dec, do_preset;

  always_comb begin
    do_dec    = en_i & tick_i;
    do_preset = cap_evt_i & preset_en_i;
    unf_o     = do_dec & (cnt_q == '0);
    cnt_ce    = do_dec | do_preset;
    cnt_d     = cnt_q;
    if (do_preset)   cnt_d = ALL_ONES;
    else if (do_dec) cnt_d = cnt_q - 1'b1;
    cap_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= ALL_ONES;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cap_q <= '0;
    else if (cap_evt_i) cap_q <= cap_d;
  end

  assign cap_val_o = cap_q;

  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !(cap_evt_i && preset_en_i) && cnt_q != '0)
      |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(en_i && tick_i) && !(cap_evt_i && preset_en_i)) |=> $stable(cnt_q));
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_o && !cap_evt_i) |=> cnt_q == ALL_ONES);
  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> cap_q == $past(cnt_q));
  assert_preset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt_i && preset_en_i) |=> cnt_q == ALL_ONES);
endmodule

// File: rtl/cap_irq.sv
module cap_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q, pend_d, pend_ce;

  for (genvar g = 0; g < N; g++) begin : g_src
    always_comb begin
      pend_ce[g] = set_i[g] | clr_i[g];
      pend_d[g]  = set_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pend_q[g] <= 1'b0;
      else if (pend_ce[g]) pend_q[g] <= pend_d[g];
    end

    assert_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_q[g]);
    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !pend_q[g]);
    assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q[g] && !clr_i[g]) |=> pend_q[g]);
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & ie_i);
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             timer_en_i,
  input  logic             cap_pin_i,
  input  logic             edge_sel_i,
  input  logic             preset_en_i,
  input  logic             cap_ie_i,
  input  logic             unf_ie_i,
  input  logic             cap_clr_i,
  input  logic             unf_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_pend_o,
  output logic             unf_pend_o,
  output logic             irq_o
);
  logic [1:0]       rst_q;
  logic             rst_int_n;
  logic             cap_evt, unf_evt;
  edge_pol_e        pol;
  logic [SRC_N-1:0] set_v, clr_v, ie_v, pend_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= '0;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  assign pol = edge_pol_e'(edge_sel_i);

  cap_sync_edge #(.SYNC_N(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .pin_i  (cap_pin_i),
    .pol_i  (pol),
    .evt_o  (cap_evt)
  );

  cap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .tick_i      (tick_i),
    .en_i        (timer_en_i),
    .cap_evt_i   (cap_evt),
    .preset_en_i (preset_en_i),
    .cap_val_o   (cap_val_o),
    .unf_o       (unf_evt)
  );

  always_comb begin
    set_v[SRC_CAP] = cap_evt;
    set_v[SRC_UNF] = unf_evt;
    clr_v[SRC_CAP] = cap_clr_i;
    clr_v[SRC_UNF] = unf_clr_i;
    ie_v[SRC_CAP]  = cap_ie_i;
    ie_v[SRC_UNF]  = unf_ie_i;
  end

  cap_irq #(.N(SRC_N)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .ie_i   (ie_v),
    .pend_o (pend_v),
    .irq_o  (irq_o)
  );

  assign cap_pend_o = pend_v[SRC_CAP];
  assign unf_pend_o = pend_v[SRC_UNF];

  // R7: coincident capture and underflow leave both flags set
  assert_both_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (cap_evt && unf_evt) |=> (cap_pend_o && unf_pend_o));
  // R1: nothing pending while reset is held internally
  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_int_n |-> (!cap_pend_o && !unf_pend_o));
endmodule

// File: tb/cap_timer_bench.sv
module cap_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, en = 1'b0, pin = 1'b0, esel = 1'b0, pre = 1'b0;
  logic        cie = 1'b0, uie = 1'b0, cclr = 1'b0, uclr = 1'b0;
  logic [15:0] cap_val;
  logic        cap_pend, unf_pend, irq;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  int m_cnt, m_cap, m_cp, m_up;
  int hist[$];

  always #5 clk = ~clk;

  cap_timer u_cap_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .timer_en_i(en),
    .cap_pin_i(pin), .edge_sel_i(esel), .preset_en_i(pre),
    .cap_ie_i(cie), .unf_ie_i(uie), .cap_clr_i(cclr), .unf_clr_i(uclr),
    .cap_val_o(cap_val), .cap_pend_o(cap_pend), .unf_pend_o(unf_pend), .irq_o(irq)
  );

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 16'hFFFF; m_cap = 0; m_cp = 0; m_up = 0;
      hist = '{0, 0, 0};
    end else begin
      bit ev, uf;
      ev = esel ? (hist[2] == 1 && hist[1] == 0) : (hist[1] == 1 && hist[2] == 0);
      uf = en && tick && m_cnt == 0;
      if (ev) m_cap = m_cnt;
      if (ev && pre)      m_cnt = 16'hFFFF;
      else if (en && tick) m_cnt = (m_cnt - 1) & 16'hFFFF;
      if (ev) m_cp = 1; else if (cclr) m_cp = 0;
      if (uf) m_up = 1; else if (uclr) m_up = 0;
      hist.push_front(int'(pin));
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R4 cap_val", int'(cap_val), m_cap);
      check("R6 cap_pend", int'(cap_pend), m_cp);
      check("R3 unf_pend", int'(unf_pend), m_up);
      check("R9 irq", int'(irq), int'((m_cp && cie) || (m_up && uie)));
    end
    if (cycles > 200000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_pin();
    pin = ~pin; @(negedge clk);
    pin = ~pin; idle(4);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    model_on = 1'b1;
    check("R1 cap_val", int'(cap_val), 0);
    check("R1 pend", int'({cap_pend, unf_pend, irq}), 0);

    // capture from reset count, flag and interrupt
    en = 1'b1;
    pulse_pin();
    check("R4 capture reset count", int'(cap_val), 16'hFFFF);
    check("R1 counter reset FFFF", int'(cap_val), 16'hFFFF);
    check("R6 flag set", int'(cap_pend), 1);
    check("R9 masked", int'(irq), 0);
    cie = 1'b1; #1;
    check("R9 enabled", int'(irq), 1);
    @(negedge clk); cclr = 1'b1; @(negedge clk); cclr = 1'b0; #1;
    check("R8 cleared", int'(cap_pend), 0);
    check("R9 drop", int'(irq), 0);

    // decrement and hold
    tick = 1'b1; idle(10); tick = 1'b0;
    en = 1'b0; tick = 1'b1; idle(5); tick = 1'b0; en = 1'b1;
    pulse_pin();
    check("R2 ten ticks", int'(cap_val), 16'hFFF5);

    // preset measures intervals
    pre = 1'b1;
    pulse_pin();
    check("R5 capture before preset", int'(cap_val), 16'hFFF5);
    tick = 1'b1; idle(3); tick = 1'b0;
    pulse_pin();
    check("R5 interval", int'(cap_val), 16'hFFFC);

    // falling polarity, rising ignored
    esel = 1'b1; idle(2);
    pin = 1'b1; idle(4);
    check("R10 rising ignored", int'(cap_val), 16'hFFFC);
    pin = 1'b0; idle(4);
    check("R10 falling captured", int'(cap_val), 16'hFFFF);
    esel = 1'b0; idle(2);

    // set wins over clear
    pin = 1'b1; @(negedge clk); pin = 1'b0; @(negedge clk);
    cclr = 1'b1; @(negedge clk);
    check("R8 set wins", int'(cap_pend), 1);
    @(negedge clk); cclr = 1'b0; #1;
    check("R8 clear after", int'(cap_pend), 0);
    idle(3);

    // capture coincident with underflow
    pre = 1'b1; tick = 1'b1; uie = 1'b1;
    while (m_cnt != 2) @(negedge clk);
    pin = 1'b1; @(negedge clk); pin = 1'b0; @(negedge clk); @(negedge clk);
    tick = 1'b0; #1;
    check("R7 captured zero", int'(cap_val), 0);
    check("R7 both flags", int'({cap_pend, unf_pend}), 3);
    check("R3 underflow flag", int'(unf_pend), 1);
    pre = 1'b0;
    pulse_pin();
    check("R7 counter FFFF", int'(cap_val), 16'hFFFF);
    uclr = 1'b1; cclr = 1'b1; @(negedge clk); uclr = 1'b0; cclr = 1'b0; #1;
    check("R8 both cleared", int'({cap_pend, unf_pend}), 0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick = $urandom_range(0, 1) == 1;
      en   = $urandom_range(0, 7) != 0;
      pin  = ($urandom_range(0, 3) == 0) ? ~pin : pin;
      pre  = $urandom_range(0, 1) == 1;
      cclr = $urandom_range(0, 9) == 0;
      uclr = $urandom_range(0, 9) == 0;
      cie  = $urandom_range(0, 1) == 1;
      uie  = $urandom_range(0, 1) == 1;
      if (i % 500 == 0) esel = ~esel;
    end
    idle(4);
    finish_run();
  end
endmodule